// File: doc/BRIEF.md
# Parallel Host Bus Target Interface

This block lets an embedded host on an ISA-like parallel bus exchange data with the logic behind it. It claims a 16-byte I/O address window. Inside that window it holds two reference parameter words, a result pointer and a status word. It also gives access to a result memory that a test engine fills through its own write port. When the host writes a command word, the block turns it into a single-cycle start strobe for the engine that owns that action: reference load, converter update or test run.

The host's read and write strobes are asynchronous to the internal clock. Each strobe passes through a short synchroniser, and every side effect happens once, on the trailing edge of the strobe. These side effects are register updates, command strobes, clearing done flags and advancing the result pointer. Read data follows a combinational path from the address pins, so it is valid well inside the short 3-clock word cycle. The block serves word cycles and byte cycles, with byte cycles selected by the high-byte-enable input. DMA cycles and refresh cycles leave it untouched.

Top module: `isa_slave_if`

## Requirements
- R1: `bus_cs16_n` is low exactly when `bus_addr[9:4]` equals the window base (default 0x300), `bus_aen` is low and `bus_refresh_n` is high; otherwise it is high.
- R2: `bus_dout_oe` is high only while `bus_rd_n` is low and the R1 window condition holds; `bus_dout` is zero while it is low.
- R3: A word cycle (`bus_sbhe_n`=0, address bit 0 = 0) writes and reads all 16 bits of a register. Byte offsets: 0x0 command, 0x2 reference A, 0x4 reference B, 0x6 status, 0x8 result pointer, 0xA result data. Reads of 0x0, 0xC and 0xE return 0.
- R4: Byte cycles use these lanes. With `bus_sbhe_n`=1 and bit 0 = 0, the low byte travels on D[7:0]. With `bus_sbhe_n`=1 and bit 0 = 1, the high byte travels on D[7:0]. With `bus_sbhe_n`=0 and bit 0 = 1, the high byte travels on D[15:8]. A byte write leaves the other byte unchanged, and a byte read drives the unused lane as zero.
- R5: Each accepted write takes effect exactly once, within 4 clocks after `bus_wr_n` rises. Registers do not change while no write strobe has been seen for 4 clocks.
- R6: A command write that carries the low byte acts on data bits [3:0]. Code 1 pulses `param_load_p`, code 2 pulses `dac_start_p` and code 3 pulses `test_start_p`, each for one clock. Every other code, and any command write without the low byte, produces no pulse.
- R7: Status bit 0 is `eng_dac_busy`, bit 1 is the converter done flag, bit 2 is `eng_test_busy` and bit 3 is the test done flag. A done flag is set by a one-clock pulse on its done input. A status read that carries the low byte clears only the done flags that were set during that read.
- R8: A read of offset 0xA returns `mem[pointer]`. The pointer advances by one, wrapping at the memory depth, after each such read that carries the high byte. The memory is written through `res_we`, `res_waddr` and `res_wdata`.
- R9: While `bus_aen` is high or `bus_refresh_n` is low, strobes change no register, produce no pulse and clear no flag.
- R10: After reset both references, the pointer and the done flags are zero, no pulse is active, and `bus_dout_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 10 | Host I/O address |
| bus_din | input | 16 | Host write data |
| bus_rd_n | input | 1 | Host I/O read strobe, active low |
| bus_wr_n | input | 1 | Host I/O write strobe, active low |
| bus_aen | input | 1 | High during DMA cycles |
| bus_refresh_n | input | 1 | Low during refresh cycles |
| bus_sbhe_n | input | 1 | High-byte enable, active low |
| bus_dout | output | 16 | Read data toward the host |
| bus_dout_oe | output | 1 | Drive enable for `bus_dout` |
| bus_cs16_n | output | 1 | 16-bit target acknowledgement, active low |
| eng_dac_busy | input | 1 | Converter engine busy |
| eng_dac_done | input | 1 | Converter engine done pulse |
| eng_test_busy | input | 1 | Test engine busy |
| eng_test_done | input | 1 | Test engine done pulse |
| res_we | input | 1 | Result memory write enable |
| res_waddr | input | 6 | Result memory write address |
| res_wdata | input | 16 | Result memory write data |
| ref_a | output | 16 | Reference parameter A |
| ref_b | output | 16 | Reference parameter B |
| param_load_p | output | 1 | Reference load pulse |
| dac_start_p | output | 1 | Converter update start pulse |
| test_start_p | output | 1 | Test run start pulse |

## Verification
Random writes to the two references and the pointer use all four lane combinations. Each write is read back through a lane combination chosen independently, so a wrong byte steering on either the write side or the read side shows up as a mismatch. Directed cases cover the following:
- Every command code, including an unused code and a command written without its low byte. These separate correct decoding from a plain level compare.
- Done flags read through the high byte, which must not clear them.
- Byte-wise reads of result data, where the pointer may advance only after the high byte.
- A pointer wrap at the top of the memory.
- Addresses outside the window and DMA or refresh cycles, which must leave every register and strobe untouched.

// File: rtl/isa_pkg.sv
// Shared constants, types and byte-lane helpers for the host bus target.
// Assumes a 16-bit data bus with two byte lanes.
package isa_pkg;
    localparam int BUS_W = 16;
    localparam int OFS_W = 3;   // word offsets inside a 16-byte window

    localparam logic [OFS_W-1:0] OFS_CMD    = 3'd0;
    localparam logic [OFS_W-1:0] OFS_REF_A  = 3'd1;
    localparam logic [OFS_W-1:0] OFS_REF_B  = 3'd2;
    localparam logic [OFS_W-1:0] OFS_STATUS = 3'd3;
    localparam logic [OFS_W-1:0] OFS_RPTR   = 3'd4;
    localparam logic [OFS_W-1:0] OFS_RDATA  = 3'd5;

    typedef enum logic [3:0] {
        CMD_NOP      = 4'd0,
        CMD_LOAD_REF = 4'd1,
        CMD_DAC_GO   = 4'd2,
        CMD_TEST_GO  = 4'd3
    } cmd_code_e;

    typedef struct packed {
        logic             valid;
        logic [OFS_W-1:0] ofs;
        logic             a0;
        logic             sbhe_n;
        logic [BUS_W-1:0] din;
    } access_t;

    // Merge host write data into a register according to the byte lanes.
    function automatic logic [BUS_W-1:0] lane_merge(
        input logic [BUS_W-1:0] old_w, input logic [BUS_W-1:0] din,
        input logic sbhe_n, input logic a0);
        case ({sbhe_n, a0})
            2'b00:   return din;
            2'b10:   return {old_w[15:8], din[7:0]};
            2'b11:   return {din[7:0], old_w[7:0]};
            default: return {din[15:8], old_w[7:0]};
        endcase
    endfunction

    // Place a register word on the host data lanes for a read.
    function automatic logic [BUS_W-1:0] lane_view(
        input logic [BUS_W-1:0] w, input logic sbhe_n, input logic a0);
        case ({sbhe_n, a0})
            2'b00:   return w;
            2'b10:   return {8'h00, w[7:0]};
            2'b11:   return {8'h00, w[15:8]};
            default: return {w[15:8], 8'h00};
        endcase
    endfunction

    // True when the access carries the low byte of the register.
    function automatic logic has_low(input logic a0);
        return !a0;
    endfunction

    // True when the access carries the high byte of the register.
    function automatic logic has_high(input logic sbhe_n, input logic a0);
        return a0 || !sbhe_n;
    endfunction
endpackage

// File: rtl/isa_strobe_sync.sv
// Synchronises an active-low host strobe into the internal clock domain.
// Gives a capture enable while the strobe is seen steadily active and a
// one-clock pulse on its trailing edge. Assumes STAGES >= 2.
module isa_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic cap_en,
    output logic trail
);
    logic [STAGES-1:0] sh;
    logic              last;

    // Shift the raw strobe through the synchroniser and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '1;
            last <= 1'b1;
        end else begin
            sh   <= {sh[STAGES-2:0], strobe_n};
            last <= sh[STAGES-1];
        end
    end

    assign cap_en = !sh[STAGES-1] && !sh[STAGES-2];
    assign trail  = sh[STAGES-1] && !last;
endmodule

// File: rtl/isa_addr_decode.sv
// Decodes the host address into window hit, word offset and byte select.
// DMA cycles (aen high) and refresh cycles never hit the window.
module isa_addr_decode
    import isa_pkg::*;
#(
    parameter int              ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h300
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              aen,
    input  logic              refresh_n,
    output logic              hit,
    output logic [OFS_W-1:0]  ofs,
    output logic              a0
);
    localparam int WIN_LSB = OFS_W + 1;

    // Compare the upper address bits and exclude non-I/O cycle types.
    always_comb begin
        hit = (addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB])
              && !aen && refresh_n;
        ofs = addr[OFS_W:1];
        a0  = addr[0];
    end
endmodule

// File: rtl/isa_result_mem.sv
// Result memory: one synchronous write port for the test engine and one
// asynchronous read port for the host. Contents are not reset.
module isa_result_mem
    import isa_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [BUS_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [BUS_W-1:0] rdata
);
    logic [BUS_W-1:0] mem [DEPTH];

    // Store one engine result per clock when enabled.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/isa_regfile.sv
// Control registers, command decode and status flags. Captures each host
// access while its strobe is steady, then acts on it once at the trailing
// edge. Assumes address and data stay valid until the strobe is synchronised.
module isa_regfile
    import isa_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cap_en,
    input  logic             wr_trail,
    input  logic             rd_cap_en,
    input  logic             rd_trail,
    input  access_t          cur,
    input  logic             dac_busy,
    input  logic             dac_done_in,
    input  logic             test_busy,
    input  logic             test_done_in,
    output logic [BUS_W-1:0] ref_a,
    output logic [BUS_W-1:0] ref_b,
    output logic [PTR_W-1:0] ptr,
    output logic [BUS_W-1:0] status,
    output logic             param_load_p,
    output logic             dac_start_p,
    output logic             test_start_p
);
    access_t     wr_cap, rd_cap;
    logic [1:0]  done, rd_snap, clr;
    logic        wr_act, rd_act;
    logic [BUS_W-1:0] ptr_wide;

    assign wr_act   = wr_trail && wr_cap.valid;
    assign rd_act   = rd_trail && rd_cap.valid;
    assign ptr_wide = {{(BUS_W-PTR_W){1'b0}}, ptr};

    // Hold the latest write access seen during the strobe; drop it once used.
    always_ff @(posedge clk) begin
        if (!rst_n)          wr_cap <= '0;
        else if (wr_cap_en)  wr_cap <= cur;
        else if (wr_trail)   wr_cap.valid <= 1'b0;
    end

    // Hold the latest read access and the done flags the host is seeing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cap  <= '0;
            rd_snap <= '0;
        end else if (rd_cap_en) begin
            rd_cap  <= cur;
            rd_snap <= done;
        end else if (rd_trail) begin
            rd_cap.valid <= 1'b0;
        end
    end

    // Write registers and move the result pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_a <= '0;
            ref_b <= '0;
            ptr   <= '0;
        end else if (wr_act) begin
            case (wr_cap.ofs)
                OFS_REF_A: ref_a <= lane_merge(ref_a, wr_cap.din, wr_cap.sbhe_n, wr_cap.a0);
                OFS_REF_B: ref_b <= lane_merge(ref_b, wr_cap.din, wr_cap.sbhe_n, wr_cap.a0);
                OFS_RPTR:  ptr   <= PTR_W'(lane_merge(ptr_wide, wr_cap.din,
                                                      wr_cap.sbhe_n, wr_cap.a0));
                default: ;
            endcase
        end else if (rd_act && rd_cap.ofs == OFS_RDATA
                     && has_high(rd_cap.sbhe_n, rd_cap.a0)) begin
            ptr <= ptr + 1'b1;
        end
    end

    // Turn a command write into a one-clock start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            param_load_p <= 1'b0;
            dac_start_p  <= 1'b0;
            test_start_p <= 1'b0;
        end else begin
            param_load_p <= 1'b0;
            dac_start_p  <= 1'b0;
            test_start_p <= 1'b0;
            if (wr_act && wr_cap.ofs == OFS_CMD && has_low(wr_cap.a0)) begin
                case (cmd_code_e'(wr_cap.din[3:0]))
                    CMD_LOAD_REF: param_load_p <= 1'b1;
                    CMD_DAC_GO:   dac_start_p  <= 1'b1;
                    CMD_TEST_GO:  test_start_p <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    assign clr = (rd_act && rd_cap.ofs == OFS_STATUS && has_low(rd_cap.a0))
                 ? rd_snap : 2'b00;

    // Keep sticky done flags; a new pulse wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= '0;
        else        done <= (done & ~clr) | {test_done_in, dac_done_in};
    end

    assign status = {{(BUS_W-4){1'b0}}, done[1], test_busy, done[0], dac_busy};
endmodule

// File: rtl/isa_slave_if.sv
// Host bus target top. Synchronises the strobes, decodes the window,
// drives read data combinationally from the address while the read strobe
// is active, and passes accepted accesses to the register file.
module isa_slave_if
    import isa_pkg::*;
#(
    parameter int                ADDR_W      = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 10'h300,
    parameter int                RES_DEPTH   = 64,
    parameter int                SYNC_STAGES = 2,
    localparam int               PTR_W       = $clog2(RES_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_din,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic              bus_aen,
    input  logic              bus_refresh_n,
    input  logic              bus_sbhe_n,
    output logic [BUS_W-1:0]  bus_dout,
    output logic              bus_dout_oe,
    output logic              bus_cs16_n,
    input  logic              eng_dac_busy,
    input  logic              eng_dac_done,
    input  logic              eng_test_busy,
    input  logic              eng_test_done,
    input  logic              res_we,
    input  logic [PTR_W-1:0]  res_waddr,
    input  logic [BUS_W-1:0]  res_wdata,
    output logic [BUS_W-1:0]  ref_a,
    output logic [BUS_W-1:0]  ref_b,
    output logic              param_load_p,
    output logic              dac_start_p,
    output logic              test_start_p
);
    logic             hit, a0, wr_cap_en, wr_trail, rd_cap_en, rd_trail;
    logic [OFS_W-1:0] ofs;
    logic [PTR_W-1:0] ptr;
    logic [BUS_W-1:0] status, mem_q, word_q;
    access_t          cur;

    isa_addr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr(bus_addr), .aen(bus_aen), .refresh_n(bus_refresh_n),
        .hit(hit), .ofs(ofs), .a0(a0));

    isa_strobe_sync #(.STAGES(SYNC_STAGES)) u_wsync (
        .clk(clk), .rst_n(rst_n), .strobe_n(bus_wr_n),
        .cap_en(wr_cap_en), .trail(wr_trail));

    isa_strobe_sync #(.STAGES(SYNC_STAGES)) u_rsync (
        .clk(clk), .rst_n(rst_n), .strobe_n(bus_rd_n),
        .cap_en(rd_cap_en), .trail(rd_trail));

    assign cur = '{valid: hit, ofs: ofs, a0: a0, sbhe_n: bus_sbhe_n, din: bus_din};

    isa_regfile #(.PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_cap_en(wr_cap_en), .wr_trail(wr_trail),
        .rd_cap_en(rd_cap_en), .rd_trail(rd_trail), .cur(cur),
        .dac_busy(eng_dac_busy), .dac_done_in(eng_dac_done),
        .test_busy(eng_test_busy), .test_done_in(eng_test_done),
        .ref_a(ref_a), .ref_b(ref_b), .ptr(ptr), .status(status),
        .param_load_p(param_load_p), .dac_start_p(dac_start_p),
        .test_start_p(test_start_p));

    isa_result_mem #(.DEPTH(RES_DEPTH)) u_mem (
        .clk(clk), .we(res_we), .waddr(res_waddr), .wdata(res_wdata),
        .raddr(ptr), .rdata(mem_q));

    // Select the addressed word for a host read.
    always_comb begin
        case (ofs)
            OFS_REF_A:  word_q = ref_a;
            OFS_REF_B:  word_q = ref_b;
            OFS_STATUS: word_q = status;
            OFS_RPTR:   word_q = {{(BUS_W-PTR_W){1'b0}}, ptr};
            OFS_RDATA:  word_q = mem_q;
            default:    word_q = '0;
        endcase
    end

    // Drive the data lanes and acknowledgements from the raw bus signals.
    always_comb begin
        bus_cs16_n  = !hit;
        bus_dout_oe = hit && !bus_rd_n;
        bus_dout    = bus_dout_oe ? lane_view(word_q, bus_sbhe_n, a0) : '0;
    end
endmodule

// File: rtl/isa_slave_chk.sv
// Protocol checker bound to the host bus target. Watches ports only.
module isa_slave_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rd_n,
    input logic        bus_wr_n,
    input logic        bus_aen,
    input logic        bus_refresh_n,
    input logic        bus_dout_oe,
    input logic        bus_cs16_n,
    input logic [15:0] ref_a,
    input logic [15:0] ref_b,
    input logic        param_load_p,
    input logic        dac_start_p,
    input logic        test_start_p
);
    localparam int QUIET = SYNC_STAGES + 2;
    int unsigned idle_cnt;

    // Count clocks since the write strobe was last seen active.
    always_ff @(posedge clk) begin
        if (!rst_n)         idle_cnt <= 0;
        else if (!bus_wr_n) idle_cnt <= 0;
        else if (idle_cnt < QUIET) idle_cnt <= idle_cnt + 1;
    end

    AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dout_oe |-> (!bus_rd_n && !bus_aen && bus_refresh_n)); // R2
    AST_CS16_NOT_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs16_n |-> (!bus_aen && bus_refresh_n)); // R1
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (param_load_p || dac_start_p || test_start_p)
        |=> !(param_load_p || dac_start_p || test_start_p)); // R6
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({param_load_p, dac_start_p, test_start_p})); // R6
    AST_REF_A_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt >= QUIET) |-> $stable(ref_a)); // R5
    AST_REF_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt >= QUIET) |-> $stable(ref_b)); // R5
endmodule

bind isa_slave_if isa_slave_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_aen(bus_aen), .bus_refresh_n(bus_refresh_n),
    .bus_dout_oe(bus_dout_oe), .bus_cs16_n(bus_cs16_n),
    .ref_a(ref_a), .ref_b(ref_b), .param_load_p(param_load_p),
    .dac_start_p(dac_start_p), .test_start_p(test_start_p));

// File: tb/tb_isa_slave_if.sv
// Self-checking bench: seeded random register traffic plus directed cases.
module tb_isa_slave_if;
    localparam logic [9:0] BASE = 10'h300;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [15:0] bus_din = '0, bus_dout, ref_a, ref_b, res_wdata = '0;
    logic        bus_rd_n = 1'b1, bus_wr_n = 1'b1, bus_aen = 1'b0;
    logic        bus_refresh_n = 1'b1, bus_sbhe_n = 1'b0;
    logic        bus_dout_oe, bus_cs16_n;
    logic        dac_busy = 0, dac_done = 0, test_busy = 0, test_done = 0;
    logic        res_we = 1'b0;
    logic [5:0]  res_waddr = '0;
    logic        param_load_p, dac_start_p, test_start_p;

    int checks = 0, failures = 0;
    int n_load = 0, n_dac = 0, n_test = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    isa_slave_if dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_din(bus_din),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_aen(bus_aen),
        .bus_refresh_n(bus_refresh_n), .bus_sbhe_n(bus_sbhe_n),
        .bus_dout(bus_dout), .bus_dout_oe(bus_dout_oe), .bus_cs16_n(bus_cs16_n),
        .eng_dac_busy(dac_busy), .eng_dac_done(dac_done),
        .eng_test_busy(test_busy), .eng_test_done(test_done),
        .res_we(res_we), .res_waddr(res_waddr), .res_wdata(res_wdata),
        .ref_a(ref_a), .ref_b(ref_b), .param_load_p(param_load_p),
        .dac_start_p(dac_start_p), .test_start_p(test_start_p));

    // Count start pulses (clock-high cycles) on each strobe.
    always @(posedge clk) begin
        if (rst_n) begin
            n_load += int'(param_load_p);
            n_dac  += int'(dac_start_p);
            n_test += int'(test_start_p);
        end
    end

    function automatic logic [15:0] mrg(logic [15:0] o, logic [15:0] d, logic sb, logic a0);
        if (!sb && !a0) return d;
        if (sb && !a0)  return {o[15:8], d[7:0]};
        if (sb && a0)   return {d[7:0], o[7:0]};
        return {d[15:8], o[7:0]};
    endfunction

    function automatic logic [15:0] view(logic [15:0] w, logic sb, logic a0);
        if (!sb && !a0) return w;
        if (sb && !a0)  return {8'h00, w[7:0]};
        if (sb && a0)   return {8'h00, w[15:8]};
        return {w[15:8], 8'h00};
    endfunction

    function automatic logic [15:0] pat(int i);
        return 16'(i * 16'h1357) ^ 16'hA5C3;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [15:0] d,
                             input logic sb, input logic aen_v, input logic rf);
        @(negedge clk);
        bus_addr = a; bus_din = d; bus_sbhe_n = sb; bus_aen = aen_v; bus_refresh_n = rf;
        @(negedge clk); bus_wr_n = 1'b0;
        repeat (5) @(negedge clk);
        bus_wr_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_aen = 1'b0; bus_refresh_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_read(input logic [9:0] a, input logic sb, input logic aen_v,
                            input logic rf, output logic [15:0] d, output logic oe,
                            output logic cs);
        @(negedge clk);
        bus_addr = a; bus_sbhe_n = sb; bus_aen = aen_v; bus_refresh_n = rf;
        @(negedge clk); bus_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        d = bus_dout; oe = bus_dout_oe; cs = bus_cs16_n;
        bus_rd_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_aen = 1'b0; bus_refresh_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic eng_write(input int i);
        @(negedge clk);
        res_we = 1'b1; res_waddr = 6'(i); res_wdata = pat(i);
        @(negedge clk); res_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (60000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] d, ma, mb, mp, ov;
        logic oe, cs;
        int l0, d0, t0;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10 reset state
        chk("R10 oe idle", 32'(bus_dout_oe), 0);
        chk("R10 ref_a", 32'(ref_a), 0);
        chk("R10 ref_b", 32'(ref_b), 0);
        bus_read(BASE + 10'h8, 1'b0, 0, 1, d, oe, cs);
        chk("R10 ptr", 32'(d), 0);
        bus_read(BASE + 10'h6, 1'b0, 0, 1, d, oe, cs);
        chk("R10 status", 32'(d), 0);
        chk("R10 no pulses", 32'(n_load + n_dac + n_test), 0);

        // R3 word write and read, R1 acknowledgement, R2 drive
        bus_write(BASE + 10'h2, 16'hBEEF, 1'b0, 0, 1);
        chk("R5 ref_a port", 32'(ref_a), 32'hBEEF);
        bus_read(BASE + 10'h2, 1'b0, 0, 1, d, oe, cs);
        chk("R3 word read", 32'(d), 32'hBEEF);
        chk("R2 oe in window", 32'(oe), 1);
        chk("R1 cs16 in window", 32'(cs), 0);
        bus_read(BASE + 10'h0, 1'b0, 0, 1, d, oe, cs);
        chk("R3 cmd reads zero", 32'(d), 0);
        bus_read(BASE + 10'hE, 1'b0, 0, 1, d, oe, cs);
        chk("R3 spare reads zero", 32'(d), 0);

        // R1 / R2 / R9 out of window and DMA / refresh
        bus_read(BASE + 10'h12, 1'b0, 0, 1, d, oe, cs);
        chk("R2 oe out of window", 32'(oe), 0);
        chk("R1 cs16 out of window", 32'(cs), 1);
        chk("R2 dout zero", 32'(d), 0);
        bus_read(BASE + 10'h2, 1'b0, 1, 1, d, oe, cs);
        chk("R9 oe in DMA", 32'(oe), 0);
        chk("R1 cs16 in DMA", 32'(cs), 1);
        bus_write(BASE + 10'h12, 16'h1111, 1'b0, 0, 1);
        bus_write(BASE + 10'h2, 16'h2222, 1'b0, 1, 1);
        bus_write(BASE + 10'h2, 16'h3333, 1'b0, 0, 0);
        bus_write(BASE + 10'h0, 16'h0003, 1'b0, 1, 1);
        chk("R9 ref_a untouched", 32'(ref_a), 32'hBEEF);
        chk("R9 no pulse in DMA", 32'(n_test), 0);

        // R3 / R4 seeded random traffic with independent read lanes
        ma = 16'hBEEF; mb = 16'h0000; mp = 16'h0000;
        for (int i = 0; i < 40; i++) begin
            int unsigned r = $urandom;
            int sel = int'(r % 3);
            logic sb = r[4], a0 = r[5], rsb = r[6], ra0 = r[7];
            logic [15:0] dat = 16'($urandom);
            logic [9:0] off = (sel == 0) ? 10'h2 : (sel == 1) ? 10'h4 : 10'h8;
            bus_write(BASE + off + 10'(a0), dat, sb, 0, 1);
            if (sel == 0) ma = mrg(ma, dat, sb, a0);
            else if (sel == 1) mb = mrg(mb, dat, sb, a0);
            else mp = {10'h0, mrg(mp, dat, sb, a0)[5:0]};
            bus_read(BASE + off + 10'(ra0), rsb, 0, 1, d, oe, cs);
            ov = (sel == 0) ? ma : (sel == 1) ? mb : mp;
            chk((sb || rsb) ? "R4 byte lanes" : "R3 word path", 32'(d), 32'(view(ov, rsb, ra0)));
        end
        chk("R5 ref_b port", 32'(ref_b), 32'(mb));

        // R6 / R5 command decode
        l0 = n_load; d0 = n_dac; t0 = n_test;
        bus_write(BASE, 16'hFF01, 1'b0, 0, 1);
        chk("R6 load pulse", 32'(n_load - l0), 1);
        bus_write(BASE, 16'h0002, 1'b1, 0, 1);
        chk("R6 dac pulse", 32'(n_dac - d0), 1);
        bus_write(BASE, 16'h0003, 1'b0, 0, 1);
        chk("R5 test pulse once", 32'(n_test - t0), 1);
        bus_write(BASE, 16'h0007, 1'b0, 0, 1);
        bus_write(BASE + 10'h1, 16'h0003, 1'b1, 0, 1);
        chk("R6 unused code and high-byte cmd", 32'(n_load - l0 + n_dac - d0 + n_test - t0), 3);

        // R7 status busy, sticky done and read clear
        @(negedge clk); dac_busy = 1; test_done = 1;
        @(negedge clk); test_done = 0;
        bus_read(BASE + 10'h6, 1'b1, 0, 1, d, oe, cs);
        chk("R7 busy and done", 32'(d), 32'h0009);
        bus_read(BASE + 10'h6, 1'b0, 0, 1, d, oe, cs);
        chk("R7 done cleared", 32'(d), 32'h0001);
        @(negedge clk); dac_busy = 0; dac_done = 1; test_busy = 1;
        @(negedge clk); dac_done = 0;
        bus_read(BASE + 10'h7, 1'b1, 0, 1, d, oe, cs);
        chk("R7 high byte read", 32'(d), 0);
        bus_read(BASE + 10'h6, 1'b1, 0, 1, d, oe, cs);
        chk("R7 done kept", 32'(d), 32'h0006);
        bus_read(BASE + 10'h6, 1'b1, 0, 1, d, oe, cs);
        chk("R7 done cleared by byte", 32'(d), 32'h0004);

        // R8 result memory through pointer
        for (int i = 0; i < 64; i++) eng_write(i);
        bus_write(BASE + 10'h8, 16'd5, 1'b0, 0, 1);
        for (int i = 5; i < 8; i++) begin
            bus_read(BASE + 10'hA, 1'b0, 0, 1, d, oe, cs);
            chk("R8 word stream", 32'(d), 32'(pat(i)));
        end
        bus_read(BASE + 10'hA, 1'b1, 0, 1, d, oe, cs);
        chk("R8 low byte", 32'(d), 32'(pat(8) & 16'h00FF));
        bus_read(BASE + 10'hB, 1'b1, 0, 1, d, oe, cs);
        chk("R8 high byte same entry", 32'(d), 32'(pat(8) >> 8));
        bus_read(BASE + 10'hA, 1'b0, 0, 1, d, oe, cs);
        chk("R8 advance after high byte", 32'(d), 32'(pat(9)));
        bus_write(BASE + 10'h8, 16'd63, 1'b0, 0, 1);
        bus_read(BASE + 10'hA, 1'b0, 0, 1, d, oe, cs);
        chk("R8 last entry", 32'(d), 32'(pat(63)));
        bus_read(BASE + 10'h8, 1'b0, 0, 1, d, oe, cs);
        chk("R8 pointer wrap", 32'(d), 0);

        finish_run();
    end
endmodule